// File: doc/BRIEF.md
# Serial LED Status Stream Transmitter

This block sends the LED state of every drive port to an external enclosure controller over a four-wire serial general-purpose bus. The wires are a bit clock, a load/frame strobe and two data lines. Each wire has its own output enable, so the whole bus can float. Software programs the locate and fault values for each port, an optional vendor pattern and a port-implemented mask, then raises a transmit request. Hardware supplies the activity state of each port.

The block stays off the bus (all enables low) after any reset until the first accepted transmit request. A transmit request starts one frame. The frame has five bit slots with the strobe low, then one slot with the strobe high. After that come the data slots. The strobe carries the vendor pattern in the first four data slots. The first data line carries three bits for every port, and the second carries only the two upper ports. The LED values are captured when the frame starts, and the busy flag drops when the last slot ends.

A reset request from software, a host controller reset or a cleared enable never cuts a frame short. The pins float only once the frame is done. The asynchronous platform reset floats them at once.

Top module: `sgpio_led_tx`

## Requirements
- R1: After any reset all four output enables are 0 and stay 0 until a transmit request is accepted. After a frame that ends without a reset request, the pins stay driven, with the bit clock, strobe and data held at 0.
- R2: Every frame starts with 5 bit slots in which the strobe is 0 and driven, followed by one slot with the strobe at 1. Both data lines are 0 in these 6 slots.
- R3: In data slots 0 to 3 the strobe carries vendor pattern bits 0 to 3, bit 0 first, and it is 0 in later slots. The vendor register resets to 0000.
- R4: The first data line carries 18 data slots. Slot k carries bit k%3 of the group of port k/3. The order inside a group is activity (0), locate (1), fault (2).
- R5: The second data line carries the groups of port 4 and then port 5 in data slots 0 to 5, in the same bit order. Its output enable is 0 for data slots 6 to 17.
- R6: Write data bit 2p+1 is the locate value of port p and bit 2p is its fault value. Both reset to 1. The activity bit of port p equals the activity input of port p.
- R7: All three bits of a port whose port-implemented bit is 0 are sent as 1, whatever was programmed and whatever the activity input is.
- R8: Driving the platform reset low clears all output enables and the busy flag at once, without waiting for a clock edge. It also returns the LED and vendor registers to their reset values.
- R9: A reset request arriving during a frame lets the frame finish all 24 slots and then clears all enables. The reset request can be the control reset pulse, the host reset pulse or the enable input at 0. A host reset while no frame is running clears the enables on the next clock. A transmit request while enable is 0 is ignored.
- R10: The busy flag is 1 from the clock after an accepted request until the last of the 24 slots ends. LED, vendor and activity values are captured at the frame start, and writes during the frame do not change the frame being sent.
- R11: Each bit slot lasts 2*HALF_DIV clocks, with the bit clock low for the first half and high for the second. Data and strobe change only where the bit clock falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous platform reset, active low |
| host_rst | input | 1 | Host controller reset pulse (synchronous reset request) |
| enable | input | 1 | Enclosure messaging enable; 0 requests a synchronous reset |
| tm_set | input | 1 | Transmit request pulse |
| ctl_reset | input | 1 | Software reset request pulse |
| tm_busy | output | 1 | Transmit bit, cleared by hardware at frame end |
| led_wr | input | 1 | Write strobe for the locate/fault register |
| led_wdata | input | 2*NUM_PORTS | Locate/fault values, two bits per port |
| vend_wr | input | 1 | Write strobe for the vendor pattern |
| vend_wdata | input | VEND_W | Vendor pattern value |
| port_impl | input | NUM_PORTS | Port-implemented mask |
| act_in | input | NUM_PORTS | Per-port activity from hardware |
| sclk_o | output | 1 | Bit clock |
| sclk_oe | output | 1 | Bit clock output enable |
| sload_o | output | 1 | Load/frame strobe |
| sload_oe | output | 1 | Strobe output enable |
| sdo0_o | output | 1 | First data line |
| sdo0_oe | output | 1 | First data line output enable |
| sdo1_o | output | 1 | Second data line |
| sdo1_oe | output | 1 | Second data line output enable |

## Verification
The hardest situation to reach from the ports is a reset arriving in the middle of a frame. The bench must show that a synchronous request lets the frame run to its 24th slot, while the platform reset floats the pins within the same clock period. To get there, the bench runs a frame capture and, in parallel, a timed agent that waits a fixed number of clocks into the frame. The agent then pulses the control reset, drops enable, or pulls the platform reset low. The capture then counts the slots that arrived and checks the enables once the frame is over. The same parallel agent also rewrites the LED registers mid-frame to show that the captured frame does not change.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;

   typedef enum logic [1:0] {
      LNK_OFF   = 2'd0,
      LNK_IDLE  = 2'd1,
      LNK_FRAME = 2'd2
   } link_st_e;

   // bit positions inside one port group, in shift order
   localparam int GRP_BITS = 3;
   localparam int POS_ACT  = 0;
   localparam int POS_LOC  = 1;
   localparam int POS_FLT  = 2;

   function automatic int bits_for(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/sgpio_sclk_gen.sv
module sgpio_sclk_gen #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic slot_end
);
   localparam int DW = sgpio_pkg::bits_for(HALF_DIV);
   localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end

   logic [DW-1:0] div_q;
   logic          ph_q;
   logic          half_end;

   assign half_end = (div_q == DIV_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         ph_q  <= 1'b0;
      end else if (!run) begin
         div_q <= '0;
         ph_q  <= 1'b0;
      end else if (half_end) begin
         div_q <= '0;
         ph_q  <= ~ph_q;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   assign sclk     = ph_q;
   assign slot_end = run & ph_q & half_end;

   // R11
   slot_end_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_end |=> !sclk);

endmodule

// File: rtl/sgpio_led_regs.sv
module sgpio_led_regs #(
   parameter int NUM_PORTS = 6,
   parameter int VEND_W    = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   led_wr,
   input  logic [2*NUM_PORTS-1:0] led_wdata,
   input  logic                   vend_wr,
   input  logic [VEND_W-1:0]      vend_wdata,
   output logic [2*NUM_PORTS-1:0] loc_flt,
   output logic [VEND_W-1:0]      vend
);
   // R6 locate/fault reset to 1, R3 vendor resets to 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loc_flt <= '1;
         vend    <= '0;
      end else begin
         if (led_wr)  loc_flt <= led_wdata;
         if (vend_wr) vend    <= vend_wdata;
      end
   end
endmodule

// File: rtl/sgpio_led_map.sv
module sgpio_led_map #(
   parameter int NUM_PORTS = 6
) (
   input  logic [NUM_PORTS-1:0]                        impl,
   input  logic [NUM_PORTS-1:0]                        act,
   input  logic [2*NUM_PORTS-1:0]                      loc_flt,
   output logic [sgpio_pkg::GRP_BITS*NUM_PORTS-1:0]    stream
);
   import sgpio_pkg::*;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      // R7 unimplemented port forces its whole group high
      assign stream[GRP_BITS*p + POS_ACT] = ~impl[p] | act[p];
      assign stream[GRP_BITS*p + POS_LOC] = ~impl[p] | loc_flt[2*p + 1];
      assign stream[GRP_BITS*p + POS_FLT] = ~impl[p] | loc_flt[2*p];
   end
endmodule

// File: rtl/sgpio_frame_seq.sv
module sgpio_frame_seq #(
   parameter int NUM_PORTS = 6,
   parameter int PRE_SLOTS = 5,
   parameter int VEND_W    = 4,
   parameter int SEC_FIRST = 4,
   parameter int SEC_PORTS = 2
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     start,
   input  logic                                     srst_req,
   input  logic                                     slot_end,
   input  logic [sgpio_pkg::GRP_BITS*NUM_PORTS-1:0] stream_live,
   input  logic [VEND_W-1:0]                        vend_live,
   output logic                                     run,
   output logic                                     drive_en,
   output logic                                     sload,
   output logic                                     sdo0,
   output logic                                     sdo1,
   output logic                                     sdo1_oe
);
   import sgpio_pkg::*;

   localparam int DATA_SLOTS  = GRP_BITS * NUM_PORTS;
   localparam int DATA0       = PRE_SLOTS + 1;
   localparam int FRAME_SLOTS = DATA0 + DATA_SLOTS;
   localparam int SEC_BITS    = GRP_BITS * SEC_PORTS;
   localparam int SEC_BASE    = GRP_BITS * SEC_FIRST;
   localparam int SW          = bits_for(FRAME_SLOTS);
   localparam int DWI         = bits_for(DATA_SLOTS);
   localparam int VIW         = bits_for(VEND_W);
   localparam int SIW         = bits_for(SEC_BITS);

   localparam logic [SW-1:0] LOAD_S    = SW'(PRE_SLOTS);
   localparam logic [SW-1:0] DATA0_S   = SW'(DATA0);
   localparam logic [SW-1:0] LAST_S    = SW'(FRAME_SLOTS - 1);
   localparam logic [SW-1:0] VEND_S    = SW'(VEND_W);
   localparam logic [SW-1:0] SEC_S     = SW'(SEC_BITS);
   localparam logic [SW-1:0] SEC_END_S = SW'(DATA0 + SEC_BITS);

   if (PRE_SLOTS < 5) begin : g_bad_pre
      $error("PRE_SLOTS must be at least 5");
   end
   if (VEND_W < 1 || VEND_W > DATA_SLOTS) begin : g_bad_vend
      $error("VEND_W must fit in the data slots");
   end
   if (SEC_PORTS < 1 || SEC_FIRST + SEC_PORTS > NUM_PORTS) begin : g_bad_sec
      $error("second line ports out of range");
   end

   link_st_e                st_q;
   logic [SW-1:0]           slot_q;
   logic                    pend_q;
   logic [DATA_SLOTS-1:0]   snap_q;
   logic [VEND_W-1:0]       vsnap_q;
   logic [SEC_BITS-1:0]     sec_snap;
   logic [SW-1:0]           d;
   logic                    in_data;
   logic                    in_sec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= LNK_OFF;
         slot_q  <= '0;
         pend_q  <= 1'b0;
         snap_q  <= '0;
         vsnap_q <= '0;
      end else begin
         case (st_q)
            LNK_OFF, LNK_IDLE: begin
               if (st_q == LNK_IDLE && srst_req) begin
                  st_q <= LNK_OFF;
               end else if (start) begin
                  st_q    <= LNK_FRAME;
                  slot_q  <= '0;
                  snap_q  <= stream_live;
                  vsnap_q <= vend_live;
               end
            end
            LNK_FRAME: begin
               if (srst_req) pend_q <= 1'b1;
               if (slot_end) begin
                  if (slot_q == LAST_S) begin
                     st_q   <= (pend_q || srst_req) ? LNK_OFF : LNK_IDLE;
                     pend_q <= 1'b0;
                     slot_q <= '0;
                  end else begin
                     slot_q <= slot_q + 1'b1;
                  end
               end
            end
            default: st_q <= LNK_OFF;
         endcase
      end
   end

   assign sec_snap = snap_q[SEC_BASE +: SEC_BITS];
   assign run      = (st_q == LNK_FRAME);
   assign drive_en = (st_q != LNK_OFF);

   always_comb begin
      d       = slot_q - DATA0_S;
      in_data = run && (slot_q >= DATA0_S);
      in_sec  = in_data && (d < SEC_S);
      sload   = run && ((slot_q == LOAD_S) ||
                        (in_data && (d < VEND_S) && vsnap_q[d[VIW-1:0]]));
      sdo0    = in_data && snap_q[d[DWI-1:0]];
      sdo1    = in_sec && sec_snap[d[SIW-1:0]];
      sdo1_oe = drive_en && !(in_data && !in_sec);
   end

   // R2
   preamble_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && slot_q < LOAD_S) |-> (!sload && !sdo0 && !sdo1 && drive_en));

   // R5
   sec_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && slot_q >= SEC_END_S) |-> !sdo1_oe);

   // R9
   frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !(slot_end && slot_q == LAST_S)) |=> run);

   // R10
   busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && slot_end && slot_q == LAST_S) |=> !run);

endmodule

// File: rtl/sgpio_led_tx.sv
module sgpio_led_tx #(
   parameter int NUM_PORTS = 6,
   parameter int HALF_DIV  = 2,
   parameter int PRE_SLOTS = 5,
   parameter int VEND_W    = 4,
   parameter int SEC_FIRST = 4,
   parameter int SEC_PORTS = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   host_rst,
   input  logic                   enable,
   input  logic                   tm_set,
   input  logic                   ctl_reset,
   output logic                   tm_busy,
   input  logic                   led_wr,
   input  logic [2*NUM_PORTS-1:0] led_wdata,
   input  logic                   vend_wr,
   input  logic [VEND_W-1:0]      vend_wdata,
   input  logic [NUM_PORTS-1:0]   port_impl,
   input  logic [NUM_PORTS-1:0]   act_in,
   output logic                   sclk_o,
   output logic                   sclk_oe,
   output logic                   sload_o,
   output logic                   sload_oe,
   output logic                   sdo0_o,
   output logic                   sdo0_oe,
   output logic                   sdo1_o,
   output logic                   sdo1_oe
);
   import sgpio_pkg::*;

   localparam int STREAM_W = GRP_BITS * NUM_PORTS;

   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("NUM_PORTS must be at least 1");
   end

   logic [2*NUM_PORTS-1:0] loc_flt;
   logic [VEND_W-1:0]      vend;
   logic [STREAM_W-1:0]    stream;
   logic                   run;
   logic                   drive_en;
   logic                   slot_end;
   logic                   sclk_raw;
   logic                   start;
   logic                   srst_req;

   assign start    = tm_set & enable & ~ctl_reset & ~host_rst;
   assign srst_req = ctl_reset | host_rst | ~enable;

   sgpio_led_regs #(.NUM_PORTS(NUM_PORTS), .VEND_W(VEND_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .led_wr(led_wr), .led_wdata(led_wdata),
      .vend_wr(vend_wr), .vend_wdata(vend_wdata),
      .loc_flt(loc_flt), .vend(vend)
   );

   sgpio_led_map #(.NUM_PORTS(NUM_PORTS)) u_map (
      .impl(port_impl), .act(act_in), .loc_flt(loc_flt), .stream(stream)
   );

   sgpio_sclk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
      .clk(clk), .rst_n(rst_n), .run(run), .sclk(sclk_raw), .slot_end(slot_end)
   );

   sgpio_frame_seq #(
      .NUM_PORTS(NUM_PORTS), .PRE_SLOTS(PRE_SLOTS), .VEND_W(VEND_W),
      .SEC_FIRST(SEC_FIRST), .SEC_PORTS(SEC_PORTS)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .srst_req(srst_req),
      .slot_end(slot_end), .stream_live(stream), .vend_live(vend),
      .run(run), .drive_en(drive_en), .sload(sload_o), .sdo0(sdo0_o),
      .sdo1(sdo1_o), .sdo1_oe(sdo1_oe)
   );

   assign tm_busy  = run;
   assign sclk_o   = sclk_raw;
   assign sclk_oe  = drive_en;
   assign sload_oe = drive_en;
   assign sdo0_oe  = drive_en;

   // R1
   float_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_oe |-> (!sload_oe && !sdo0_oe && !sdo1_oe && !tm_busy));

   // R11
   data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo0_oe && $past(sdo0_oe) && !$stable(sdo0_o)) |-> $fell(sclk_o));

   // R11
   load_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sload_oe && $past(sload_oe) && !$stable(sload_o)) |-> $fell(sclk_o));

endmodule

// File: tb/sgpio_led_tx_tb.sv
`timescale 1ns/1ps
module sgpio_led_tx_tb;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n = 1'b0, host_rst = 1'b0, enable = 1'b1, tm_set = 1'b0, ctl_reset = 1'b0;
   logic        led_wr = 1'b0, vend_wr = 1'b0;
   logic [11:0] led_wdata = '0;
   logic [3:0]  vend_wdata = '0;
   logic [5:0]  port_impl = 6'h3F, act_in = '0;
   logic        tm_busy, sclk_o, sclk_oe, sload_o, sload_oe, sdo0_o, sdo0_oe, sdo1_o, sdo1_oe;

   sgpio_led_tx u_dut (
      .clk(clk), .rst_n(rst_n), .host_rst(host_rst), .enable(enable), .tm_set(tm_set),
      .ctl_reset(ctl_reset), .tm_busy(tm_busy), .led_wr(led_wr), .led_wdata(led_wdata),
      .vend_wr(vend_wr), .vend_wdata(vend_wdata), .port_impl(port_impl), .act_in(act_in),
      .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sload_o(sload_o), .sload_oe(sload_oe),
      .sdo0_o(sdo0_o), .sdo0_oe(sdo0_oe), .sdo1_o(sdo1_o), .sdo1_oe(sdo1_oe)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;
   logic [23:0] c_sload, c_sdo0, c_sdo1, c_sdo1oe, c_sclkoe;
   int c_n, per_bad;

   // {port_impl, locate/fault, activity, vendor}
   localparam logic [27:0] VEC [6] = '{
      {6'h3F, 12'hFFF, 6'h00, 4'h0},
      {6'h3F, 12'h000, 6'h3F, 4'hA},
      {6'h15, 12'h5A3, 6'h2A, 4'h5},
      {6'h2A, 12'hC3C, 6'h15, 4'h9},
      {6'h00, 12'h000, 6'h00, 4'hF},
      {6'h30, 12'h0F0, 6'h21, 4'h6}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   function automatic logic [17:0] exp_stream(input logic [5:0] impl, input logic [11:0] lf,
                                              input logic [5:0] act);
      logic [17:0] s;
      for (int k = 0; k < 18; k++) begin
         int p = k / 3;
         int pos = k % 3;
         if (!impl[p])      s[k] = 1'b1;
         else if (pos == 0) s[k] = act[p];
         else if (pos == 1) s[k] = lf[2*p+1];
         else               s[k] = lf[2*p];
      end
      return s;
   endfunction

   task automatic write_regs(input logic [11:0] lf, input logic [3:0] v);
      @(negedge clk);
      led_wr = 1'b1; led_wdata = lf; vend_wr = 1'b1; vend_wdata = v;
      @(negedge clk);
      led_wr = 1'b0; vend_wr = 1'b0;
   endtask

   task automatic run_frame();
      bit prev;
      int t, prev_t;
      c_sload = '0; c_sdo0 = '0; c_sdo1 = '0; c_sdo1oe = '0; c_sclkoe = '0;
      c_n = 0; per_bad = 0;
      @(negedge clk); tm_set = 1'b1;
      @(negedge clk); tm_set = 1'b0;
      prev = 1'b0; t = 0; prev_t = -1;
      if (tm_busy) begin
         for (int i = 0; i < 2000; i++) begin
            @(negedge clk); t++;
            if (!tm_busy) break;
            if (!prev && sclk_o) begin
               if (c_n < 24) begin
                  c_sload[c_n]  = sload_o;
                  c_sdo0[c_n]   = sdo0_o;
                  c_sdo1[c_n]   = sdo1_o & sdo1_oe;
                  c_sdo1oe[c_n] = sdo1_oe;
                  c_sclkoe[c_n] = sclk_oe;
               end
               if (prev_t >= 0 && t - prev_t != 4) per_bad++;
               prev_t = t;
               c_n++;
            end
            prev = sclk_o;
         end
      end
   endtask

   task automatic check_frame(input logic [5:0] impl, input logic [11:0] lf,
                              input logic [5:0] act, input logic [3:0] v, input string tag);
      logic [17:0] s;
      s = exp_stream(impl, lf, act);
      chk(c_n == 24, "R10", {tag, " slot count"}, c_n, 24);
      chk(c_sload == {14'b0, v, 1'b1, 5'b0}, "R2 R3", {tag, " strobe"},
          c_sload, {14'b0, v, 1'b1, 5'b0});
      chk(c_sdo0 == {s, 6'b0}, "R4 R6 R7", {tag, " line0"}, c_sdo0, {s, 6'b0});
      chk(c_sdo1 == {12'b0, s[17:12], 6'b0} && c_sdo1oe == 24'h000FFF, "R5",
          {tag, " line1"}, {c_sdo1oe[11:0], c_sdo1[11:0]}, {12'hFFF, s[17:12], 6'b0});
      chk(per_bad == 0 && c_sclkoe == 24'hFFFFFF, "R11", {tag, " slot timing"},
          per_bad, 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!sclk_oe && !sload_oe && !sdo0_oe && !sdo1_oe && !tm_busy, "R1", "in reset",
          {sclk_oe, sload_oe, sdo0_oe, sdo1_oe}, 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(!sclk_oe && !sload_oe && !sdo0_oe && !sdo1_oe, "R1", "before first request",
          {sclk_oe, sload_oe, sdo0_oe, sdo1_oe}, 0);

      // R6 R3 defaults before any write
      port_impl = 6'h3F; act_in = 6'h00;
      run_frame();
      check_frame(6'h3F, 12'hFFF, 6'h00, 4'h0, "defaults");
      // R1 idle after frame stays driven
      chk(sclk_oe && sdo1_oe && !sclk_o && !sload_o && !sdo0_o, "R1", "idle driven",
          {sclk_oe, sdo1_oe, sclk_o, sload_o, sdo0_o}, 5'b11000);

      // vector table
      foreach (VEC[i]) begin
         logic [27:0] e;
         e = VEC[i];
         write_regs(e[21:10], e[3:0]);
         port_impl = e[27:22]; act_in = e[9:4];
         run_frame();
         check_frame(e[27:22], e[21:10], e[9:4], e[3:0], "table");
      end

      // R10 values captured at frame start
      port_impl = 6'h3F; act_in = 6'h05;
      write_regs(12'h000, 4'h3);
      fork
         run_frame();
         begin
            repeat (12) @(negedge clk);
            led_wr = 1'b1; led_wdata = 12'hFFF; vend_wr = 1'b1; vend_wdata = 4'hC;
            act_in = 6'h3A;
            @(negedge clk);
            led_wr = 1'b0; vend_wr = 1'b0;
         end
      join
      check_frame(6'h3F, 12'h000, 6'h05, 4'h3, "latched");
      chk(!tm_busy, "R10", "busy cleared", tm_busy, 0);

      // R9 control reset mid-frame
      act_in = 6'h00;
      fork
         run_frame();
         begin
            repeat (20) @(negedge clk);
            ctl_reset = 1'b1; @(negedge clk); ctl_reset = 1'b0;
         end
      join
      check_frame(6'h3F, 12'hFFF, 6'h00, 4'hC, "ctl reset");
      chk(!sclk_oe && !sload_oe && !sdo0_oe && !sdo1_oe, "R9", "float after ctl reset",
          {sclk_oe, sload_oe, sdo0_oe, sdo1_oe}, 0);

      // R9 enable dropped mid-frame
      fork
         run_frame();
         begin
            repeat (30) @(negedge clk);
            enable = 1'b0;
         end
      join
      chk(c_n == 24, "R9", "enable drop frame length", c_n, 24);
      chk(!sclk_oe && !sdo0_oe, "R9", "float after enable drop", {sclk_oe, sdo0_oe}, 0);
      run_frame();
      chk(c_n == 0 && !tm_busy && !sclk_oe, "R9", "request ignored while disabled",
          {c_n[7:0], tm_busy, sclk_oe}, 0);
      enable = 1'b1;

      // R9 host reset while idle
      run_frame();
      chk(sclk_oe, "R1", "driven after restart", sclk_oe, 1);
      @(negedge clk); host_rst = 1'b1;
      @(negedge clk); host_rst = 1'b0;
      chk(!sclk_oe && !sload_oe && !sdo0_oe && !sdo1_oe, "R9", "host reset idle",
          {sclk_oe, sload_oe, sdo0_oe, sdo1_oe}, 0);

      // R8 platform reset mid-frame
      write_regs(12'h000, 4'h7);
      fork
         run_frame();
         begin
            repeat (30) @(negedge clk);
            #0.5 rst_n = 1'b0;
            #0.5;
            chk(!sclk_oe && !sload_oe && !sdo0_oe && !sdo1_oe && !tm_busy, "R8",
                "async float", {sclk_oe, sload_oe, sdo0_oe, sdo1_oe, tm_busy}, 0);
         end
      join
      @(negedge clk); rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(!sclk_oe, "R1", "float after platform reset", sclk_oe, 0);
      act_in = 6'h00;
      run_frame();
      check_frame(6'h3F, 12'hFFF, 6'h00, 4'h0, "R8 regs reset");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule